// File: doc/BRIEF.md
# Counting Binary-to-BCD Converter

This block turns an unsigned binary operand into packed decimal digits. It does not use shift-and-add or bit-serial correction. It clears a binary counter and a chain of decimal digit counters together, then advances both on every clock until the binary count equals the captured operand. At that point the decimal counters hold the operand's decimal form, and that value is copied into the output register.

A caller pulses `start` for one cycle with the operand on `operand`. The block raises `busy` and, after a run whose length depends on the value, pulses `done` for one cycle with the new result on `bcd_out`. An operand too large for the available digits is clamped to all nines. The clamped count also bounds the longest run. The defaults are a 10-bit operand and three digits.

Top module: `cnt_bcd_conv`

## Requirements
- R1: While reset is high and after it drops, before any start, `busy` and `done` are 0 and `bcd_out` is 0.
- R2: A start pulse seen while `busy` is 0 captures `operand` and raises `busy` on the next edge. `busy` stays high until the edge that raises `done`, and it drops on that same edge.
- R3: `bcd_out` packs the hundreds digit in bits [11:8], the tens digit in bits [7:4] and the units digit in bits [3:0], each as plain 4-bit BCD.
- R4: For an operand N no greater than 999, `done` is high in the cycle that follows the edge N+1 clocks after the edge that sampled start.
- R5: Any operand above 999 gives `bcd_out` = 12'h999, with the same timing as an operand of 999.
- R6: An operand of 0 finishes one edge after start, with `bcd_out` = 12'h000.
- R7: Start pulses and operand changes while `busy` is high are ignored: they add no result and do not alter the result in progress.
- R8: `done` lasts exactly one cycle, and `bcd_out` changes only together with `done`. It holds its value between conversions.
- R9: Every digit of `bcd_out` is 0 to 9. Passing 9 on a lower digit resets that digit and carries into the next digit on the same edge, for example 9→10 and 99→100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a conversion |
| operand | input | 10 | Unsigned binary value, sampled with start |
| busy | output | 1 | High while a conversion runs |
| done | output | 1 | One-cycle pulse when `bcd_out` updates |
| bcd_out | output | 12 | Three packed BCD digits, hundreds most significant |

## Verification
Each result is due a number of cycles that depends on its value. The edge that samples start is counted as edge S, and `done` must appear right after edge S+N+1, where N is the operand clamped to 999. The driver stamps every expected value with that edge number when it raises start. The monitor, which samples on the falling clock, compares both the value and the edge count whenever `done` is seen. A `done` that arrives early, late, or with no matching entry is reported. A start ignored during a busy run adds no entry, so any extra result it caused would show up as unexpected.

// File: rtl/cnt_bcd_pkg.sv
package cnt_bcd_pkg;

  localparam int DIGIT_W = 4;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } conv_state_e;

  // largest value representable with the given number of decimal digits
  function automatic int unsigned dec_max(input int unsigned ndig);
    int unsigned v;
    v = 1;
    for (int unsigned i = 0; i < ndig; i++) v = v * 10;
    return v - 1;
  endfunction

endpackage

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
  import cnt_bcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic match,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);

  conv_state_e state_q;

  assign load   = (state_q == ST_IDLE) && start;
  assign finish = (state_q == ST_RUN) && match;
  assign step   = (state_q == ST_RUN) && !match;
  assign busy   = (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) state_q <= ST_RUN;
        ST_RUN: begin
          if (match) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cbc_bin_track.sv
module cbc_bin_track
  import cnt_bcd_pkg::*;
#(
  parameter int BIN_W = 10,
  parameter int NDIG  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [BIN_W-1:0] operand,
  output logic             match
);

  localparam int unsigned MAXV = dec_max(NDIG);
  localparam logic [31:0] MAXV32 = 32'(MAXV);

  logic [BIN_W-1:0] target_q;
  logic [BIN_W-1:0] count_q;
  logic [BIN_W-1:0] clamped;

  // out-of-range operands stop the count at the all-nines value
  always_comb begin
    if (32'(operand) > MAXV32) clamped = MAXV32[BIN_W-1:0];
    else                       clamped = operand;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      target_q <= '0;
      count_q  <= '0;
    end else if (load) begin
      target_q <= clamped;
      count_q  <= '0;
    end else if (step) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign match = (count_q == target_q);

endmodule

// File: rtl/cbc_bcd_digit.sv
module cbc_bcd_digit
  import cnt_bcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               inc,
  output logic [DIGIT_W-1:0] value,
  output logic               at_nine
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      value <= '0;
    end else if (inc) begin
      if (value == DIGIT_W'(9)) value <= '0;
      else                      value <= value + 1'b1;
    end
  end

  assign at_nine = (value == DIGIT_W'(9));

endmodule

// File: rtl/cnt_bcd_conv.sv
module cnt_bcd_conv
  import cnt_bcd_pkg::*;
#(
  parameter int BIN_W = 10,
  parameter int NDIG  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [BIN_W-1:0]        operand,
  output logic                    busy,
  output logic                    done,
  output logic [NDIG*DIGIT_W-1:0] bcd_out
);

  localparam int OUT_W = NDIG * DIGIT_W;

  logic load, step, finish, match;
  logic [NDIG-1:0]  nine;
  logic [NDIG-1:0]  inc;
  logic [OUT_W-1:0] dec_cnt;

  cbc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .match  (match),
    .load   (load),
    .step   (step),
    .finish (finish),
    .busy   (busy),
    .done   (done)
  );

  cbc_bin_track #(.BIN_W(BIN_W), .NDIG(NDIG)) u_bin (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .operand (operand),
    .match   (match)
  );

  // a digit advances when every lower digit is about to wrap
  for (genvar d = 0; d < NDIG; d++) begin : g_digit
    if (d == 0) begin : g_lsd
      assign inc[d] = step;
    end else begin : g_upper
      assign inc[d] = step && (&nine[d-1:0]);
    end
    cbc_bcd_digit u_dig (
      .clk     (clk),
      .rst     (rst),
      .clr     (load),
      .inc     (inc[d]),
      .value   (dec_cnt[d*DIGIT_W +: DIGIT_W]),
      .at_nine (nine[d])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)         bcd_out <= '0;
    else if (finish) bcd_out <= dec_cnt;
  end

endmodule

// File: rtl/cnt_bcd_conv_chk.sv
module cnt_bcd_conv_chk
  import cnt_bcd_pkg::*;
#(
  parameter int BIN_W = 10,
  parameter int NDIG  = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic [NDIG*DIGIT_W-1:0] bcd_out
);

  localparam int OP_W = BIN_W;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(bcd_out));  // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);  // R2
  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);  // R2
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));  // R2
  AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);  // R2

  for (genvar d = 0; d < NDIG; d++) begin : g_dchk
    AST_DIGIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
      bcd_out[d*DIGIT_W +: DIGIT_W] <= DIGIT_W'(9));  // R9
  end

endmodule

bind cnt_bcd_conv cnt_bcd_conv_chk #(.BIN_W(BIN_W), .NDIG(NDIG)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .bcd_out (bcd_out)
);

// File: tb/cnt_bcd_conv_tb.sv
`timescale 1ns/1ps
module cnt_bcd_conv_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [9:0]  operand = '0;
  logic        busy, done;
  logic [11:0] bcd_out;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int pend = 0;
  logic [11:0] q_val[$];
  int          q_due[$];
  string       q_tag[$];
  logic [11:0] last_val = '0;

  always #2 clk = ~clk;  // 250 MHz

  cnt_bcd_conv u_dut (
    .clk(clk), .rst(rst), .start(start), .operand(operand),
    .busy(busy), .done(done), .bcd_out(bcd_out)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [11:0] exp_bcd(input int v);
    int c;
    c = (v > 999) ? 999 : v;
    return {4'(c / 100), 4'((c / 10) % 10), 4'(c % 10)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q_val.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R7: actual unexpected result %0h expected none", bcd_out);
      end else begin
        string t;
        logic [11:0] v;
        int d;
        v = q_val.pop_front(); d = q_due.pop_front(); t = q_tag.pop_front();
        check({t, " value"}, 32'(bcd_out), 32'(v));
        check("R4 latency", 32'(cyc), 32'(d));
        check("R2 busy low at done", 32'(busy), 32'd0);
        last_val = v;
        pend--;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic issue(input int op, input string tag);
    int n;
    n = (op > 999) ? 999 : op;
    @(negedge clk);
    start = 1'b1;
    operand = 10'(op);
    q_val.push_back(exp_bcd(op));
    q_due.push_back(cyc + 1 + n + 1);
    q_tag.push_back(tag);
    pend++;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (pend != 0) @(negedge clk);
  endtask

  task automatic convert(input int op, input string tag);
    issue(op, tag);
    wait_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 busy in reset", 32'(busy), 0);
    check("R1 done in reset", 32'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 result after reset", 32'(bcd_out), 0);
    check("R1 busy after reset", 32'(busy), 0);

    convert(0, "R6");
    convert(1, "R3");
    convert(9, "R9");
    convert(10, "R9");
    convert(99, "R9");
    convert(100, "R9");
    convert(255, "R3");
    convert(509, "R4");
    convert(487, "R3");
    convert(999, "R5");
    convert(1000, "R5");
    convert(1023, "R5");

    // R7: extra start and operand change during a run
    issue(50, "R7");
    repeat (5) @(negedge clk);
    check("R2 busy during run", 32'(busy), 1);
    start = 1'b1; operand = 10'd3;
    @(negedge clk);
    start = 1'b0; operand = 10'd777;
    wait_idle();
    repeat (3) @(negedge clk);
    check("R7 no extra result", 32'(pend), 0);

    // R8: result held between conversions
    repeat (20) @(negedge clk);
    check("R8 hold value", 32'(bcd_out), 32'(last_val));
    check("R8 done low", 32'(done), 0);

    // back-to-back conversions
    convert(7, "R3");
    convert(0, "R6");
    convert(321, "R3");

    repeat (4) @(negedge clk);
    check("R7 queue drained", 32'(q_val.size()), 0);
    finish_run();
  end

endmodule